// File: doc/BRIEF.md
# Host Command Register Decoder

This block sits behind the host command link, in the system clock domain. Each command has an 8-bit opcode and a 16-bit value and arrives with a one-cycle `cmd_valid` strobe. The block keeps the radar's runtime configuration: the detection threshold, the three stream enables, the 2-bit radar mode and six chirp timing settings. It drives them as parallel outputs to the signal chain and to the chirp sequencer. Timing settings reset to nonzero values set by parameters, so the sequencer can run before the host has sent anything.

Two opcodes store nothing and act instead. One fires a single-chirp trigger pulse. The other fires a status-request pulse and, on the same clock edge, copies every configuration register into a status snapshot. The snapshot holds that copy until the next status request, so a downstream serializer can read it at its own pace.

Each action pulse comes from a two-state machine with states `PS_IDLE` and `PS_FIRE`. The transition `PS_IDLE`→`PS_FIRE` and the hold `PS_FIRE`→`PS_FIRE` are taken on a decoded action command. The transitions `PS_FIRE`→`PS_IDLE` and `PS_IDLE`→`PS_IDLE` are taken when no action command is decoded. There is one machine for the trigger and one for the status request.

Top module: `host_cfg_decoder`

## Requirements
- R1: After reset the block outputs the following. Stream enables read 3'b111. Threshold, mode and the six timing settings read their parameter defaults. Both pulses are low. The snapshot holds the default register values.
- R2: A valid opcode 0x01 loads the radar mode from value[1:0]. The mode output changes on the clock edge that samples the strobe.
- R3: A valid opcode 0x03 loads the 16-bit detection threshold from value[15:0].
- R4: A valid opcode 0x04 loads the stream enables from value[2:0]. Bit 0 is the range stream, bit 1 the Doppler stream and bit 2 the detection stream.
- R5: Valid opcodes 0x10, 0x11, 0x12, 0x13 and 0x14 load value[15:0] into, in that order, long chirp cycles, long listen cycles, guard cycles, short chirp cycles and short listen cycles.
- R6: A valid opcode 0x15 loads chirps per elevation from value[5:0]. Bits above bit 5 are dropped.
- R7: A valid opcode 0x02 raises `chirp_trigger` for exactly the cycle after the strobe, whatever the value. It changes no register.
- R8: A valid opcode 0xFF raises `status_req` for the cycle after the strobe. On that same edge it loads `status_snapshot` with the register values held before the edge. The snapshot layout, from the LSB up, is: threshold [15:0], streams [18:16], mode [20:19], long chirp [36:21], long listen [52:37], guard [68:53], short chirp [84:69], short listen [100:85], chirps per elevation [106:101].
- R9: Any opcode not listed above changes no register and fires no pulse. Any opcode presented while `cmd_valid` is low also changes no register and fires no pulse.
- R10: Action opcodes on consecutive valid cycles each give their own pulse cycle. Two back-to-back triggers hold `chirp_trigger` high for two consecutive cycles.
- R11: `status_snapshot` changes only on a status request. Register writes made after the request do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_opcode | input | 8 | Command opcode |
| cmd_value | input | 16 | Command value |
| cfg_mode | output | 2 | Radar mode |
| cfg_threshold | output | 16 | Detection threshold |
| cfg_streams | output | 3 | Stream enables (range, Doppler, detection) |
| cfg_long_chirp | output | 16 | Long chirp cycles |
| cfg_long_listen | output | 16 | Long listen cycles |
| cfg_guard | output | 16 | Guard cycles |
| cfg_short_chirp | output | 16 | Short chirp cycles |
| cfg_short_listen | output | 16 | Short listen cycles |
| cfg_chirps_per_elev | output | 6 | Chirps per elevation |
| chirp_trigger | output | 1 | Single-chirp trigger pulse |
| status_req | output | 1 | Status-request pulse |
| status_snapshot | output | 107 | Register copy taken at the last status request |

## Verification
The assertions assume that `cmd_valid`, `cmd_opcode` and `cmd_value` are synchronous to `clk` and free of X whenever reset is released. They also assume that one command at most is presented per cycle. The stimulus changes inputs only on falling edges, keeps every input at a defined value from time zero, and holds `cmd_valid` low throughout reset. Opcodes are swept over all 256 codes, with a value pattern that depends on the opcode. Back-to-back action sequences are driven on adjacent cycles.

// File: rtl/hcd_pkg.sv
package hcd_pkg;

    localparam int VAL_W = 16;
    localparam int CNT_W = 16;
    localparam int CPE_W = 6;
    localparam int MODE_W = 2;
    localparam int STR_W = 3;

    // write-enable slot indices
    localparam int W_THR  = 0;
    localparam int W_STR  = 1;
    localparam int W_MODE = 2;
    localparam int W_LC   = 3;
    localparam int W_LL   = 4;
    localparam int W_GD   = 5;
    localparam int W_SC   = 6;
    localparam int W_SL   = 7;
    localparam int W_CPE  = 8;
    localparam int NREG   = 9;

    // action slot indices
    localparam int A_TRIG = 0;
    localparam int A_STAT = 1;
    localparam int NACT   = 2;

    localparam logic [7:0] OP_MODE  = 8'h01;
    localparam logic [7:0] OP_TRIG  = 8'h02;
    localparam logic [7:0] OP_THR   = 8'h03;
    localparam logic [7:0] OP_STR   = 8'h04;
    localparam logic [7:0] OP_LC    = 8'h10;
    localparam logic [7:0] OP_LL    = 8'h11;
    localparam logic [7:0] OP_GD    = 8'h12;
    localparam logic [7:0] OP_SC    = 8'h13;
    localparam logic [7:0] OP_SL    = 8'h14;
    localparam logic [7:0] OP_CPE   = 8'h15;
    localparam logic [7:0] OP_STAT  = 8'hFF;

    typedef enum logic {PS_IDLE, PS_FIRE} pulse_st_e;

    // first member is the MSB: layout matches the snapshot port
    typedef struct packed {
        logic [CPE_W-1:0]  cpe;
        logic [CNT_W-1:0]  short_listen;
        logic [CNT_W-1:0]  short_chirp;
        logic [CNT_W-1:0]  guard;
        logic [CNT_W-1:0]  long_listen;
        logic [CNT_W-1:0]  long_chirp;
        logic [MODE_W-1:0] mode;
        logic [STR_W-1:0]  streams;
        logic [VAL_W-1:0]  thr;
    } cfg_t;

    localparam int SNAP_W = $bits(cfg_t);

    function automatic logic op_known(input logic [7:0] op);
        return (op == OP_MODE) || (op == OP_TRIG) || (op == OP_THR) ||
               (op == OP_STR)  || (op == OP_STAT) ||
               ((op >= OP_LC) && (op <= OP_CPE));
    endfunction

endpackage

// File: rtl/hcd_decode.sv
module hcd_decode
    import hcd_pkg::*;
(
    input  logic                cmd_valid,
    input  logic [7:0]          cmd_opcode,
    output logic [NREG-1:0]     wr_en,
    output logic [NACT-1:0]     act_fire
);

    always_comb begin
        wr_en    = '0;
        act_fire = '0;
        if (cmd_valid) begin
            unique case (cmd_opcode)
                OP_MODE: wr_en[W_MODE]     = 1'b1;
                OP_THR:  wr_en[W_THR]      = 1'b1;
                OP_STR:  wr_en[W_STR]      = 1'b1;
                OP_LC:   wr_en[W_LC]       = 1'b1;
                OP_LL:   wr_en[W_LL]       = 1'b1;
                OP_GD:   wr_en[W_GD]       = 1'b1;
                OP_SC:   wr_en[W_SC]       = 1'b1;
                OP_SL:   wr_en[W_SL]       = 1'b1;
                OP_CPE:  wr_en[W_CPE]      = 1'b1;
                OP_TRIG: act_fire[A_TRIG]  = 1'b1;
                OP_STAT: act_fire[A_STAT]  = 1'b1;
                default: ;
            endcase
        end
    end

    // R9: a decoded command touches at most one slot
    always_comb begin
        assert_one_slot_R9: assert ($countones({wr_en, act_fire}) <= 1)
            else $error("decoder raised more than one slot");
    end

endmodule

// File: rtl/hcd_regfile.sv
module hcd_regfile
    import hcd_pkg::*;
#(
    parameter cfg_t RST_CFG = '0
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NREG-1:0]   wr_en,
    input  logic [VAL_W-1:0]  value,
    output cfg_t              cfg
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= RST_CFG;
        end else begin
            if (wr_en[W_THR])  cfg.thr          <= value;
            if (wr_en[W_STR])  cfg.streams      <= value[STR_W-1:0];
            if (wr_en[W_MODE]) cfg.mode         <= value[MODE_W-1:0];
            if (wr_en[W_LC])   cfg.long_chirp   <= value[CNT_W-1:0];
            if (wr_en[W_LL])   cfg.long_listen  <= value[CNT_W-1:0];
            if (wr_en[W_GD])   cfg.guard        <= value[CNT_W-1:0];
            if (wr_en[W_SC])   cfg.short_chirp  <= value[CNT_W-1:0];
            if (wr_en[W_SL])   cfg.short_listen <= value[CNT_W-1:0];
            if (wr_en[W_CPE])  cfg.cpe          <= value[CPE_W-1:0];
        end
    end

    // R6: chirps-per-elevation takes the low bits of the value
    assert_cpe_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en[W_CPE] |=> cfg.cpe == $past(value[CPE_W-1:0]))
        else $error("chirps per elevation load mismatch");

    // R4: stream enables take value[2:0]
    assert_stream_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en[W_STR] |=> cfg.streams == $past(value[STR_W-1:0]))
        else $error("stream enable load mismatch");

endmodule

// File: rtl/hcd_pulse.sv
module hcd_pulse
    import hcd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic pulse
);

    pulse_st_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PS_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            PS_IDLE: state_nx = fire ? PS_FIRE : PS_IDLE;
            PS_FIRE: state_nx = fire ? PS_FIRE : PS_IDLE;
            default: state_nx = PS_IDLE;
        endcase
        pulse = (state == PS_FIRE);
    end

    // R10: each fire yields a pulse cycle, none without it
    assert_fire_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> pulse)
        else $error("action pulse missing");

    assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> !pulse)
        else $error("action pulse without command");

endmodule

// File: rtl/host_cfg_decoder.sv
module host_cfg_decoder
    import hcd_pkg::*;
#(
    parameter logic [VAL_W-1:0]  DEF_THRESHOLD    = 16'd10000,
    parameter logic [MODE_W-1:0] DEF_MODE         = 2'd0,
    parameter logic [CNT_W-1:0]  DEF_LONG_CHIRP   = 16'd3000,
    parameter logic [CNT_W-1:0]  DEF_LONG_LISTEN  = 16'd13700,
    parameter logic [CNT_W-1:0]  DEF_GUARD        = 16'd17540,
    parameter logic [CNT_W-1:0]  DEF_SHORT_CHIRP  = 16'd50,
    parameter logic [CNT_W-1:0]  DEF_SHORT_LISTEN = 16'd17450,
    parameter logic [CPE_W-1:0]  DEF_CPE          = 6'd32
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [7:0]          cmd_opcode,
    input  logic [15:0]         cmd_value,
    output logic [1:0]          cfg_mode,
    output logic [15:0]         cfg_threshold,
    output logic [2:0]          cfg_streams,
    output logic [15:0]         cfg_long_chirp,
    output logic [15:0]         cfg_long_listen,
    output logic [15:0]         cfg_guard,
    output logic [15:0]         cfg_short_chirp,
    output logic [15:0]         cfg_short_listen,
    output logic [5:0]          cfg_chirps_per_elev,
    output logic                chirp_trigger,
    output logic                status_req,
    output logic [106:0]        status_snapshot
);

    localparam cfg_t RST_CFG = '{
        cpe:          DEF_CPE,
        short_listen: DEF_SHORT_LISTEN,
        short_chirp:  DEF_SHORT_CHIRP,
        guard:        DEF_GUARD,
        long_listen:  DEF_LONG_LISTEN,
        long_chirp:   DEF_LONG_CHIRP,
        mode:         DEF_MODE,
        streams:      {STR_W{1'b1}},
        thr:          DEF_THRESHOLD
    };

    logic [NREG-1:0] wr_en;
    logic [NACT-1:0] act_fire;
    logic [NACT-1:0] act_pulse;
    cfg_t            cfg;
    cfg_t            snap;

    hcd_decode u_decode (
        .cmd_valid  (cmd_valid),
        .cmd_opcode (cmd_opcode),
        .wr_en      (wr_en),
        .act_fire   (act_fire)
    );

    hcd_regfile #(.RST_CFG(RST_CFG)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .value (cmd_value),
        .cfg   (cfg)
    );

    for (genvar a = 0; a < NACT; a++) begin : g_act
        hcd_pulse u_pulse (
            .clk   (clk),
            .rst_n (rst_n),
            .fire  (act_fire[a]),
            .pulse (act_pulse[a])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                snap <= RST_CFG;
        else if (act_fire[A_STAT]) snap <= cfg;
    end

    assign cfg_mode            = cfg.mode;
    assign cfg_threshold       = cfg.thr;
    assign cfg_streams         = cfg.streams;
    assign cfg_long_chirp      = cfg.long_chirp;
    assign cfg_long_listen     = cfg.long_listen;
    assign cfg_guard           = cfg.guard;
    assign cfg_short_chirp     = cfg.short_chirp;
    assign cfg_short_listen    = cfg.short_listen;
    assign cfg_chirps_per_elev = cfg.cpe;
    assign chirp_trigger       = act_pulse[A_TRIG];
    assign status_req          = act_pulse[A_STAT];
    assign status_snapshot     = snap;

    // R2: mode load
    assert_mode_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_opcode == OP_MODE) |=> cfg_mode == $past(cmd_value[1:0]))
        else $error("mode load mismatch");

    // R3: threshold load
    assert_thr_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_opcode == OP_THR) |=> cfg_threshold == $past(cmd_value))
        else $error("threshold load mismatch");

    // R5: guard timing load
    assert_guard_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_opcode == OP_GD) |=> cfg_guard == $past(cmd_value))
        else $error("guard load mismatch");

    // R7: trigger pulses and leaves registers alone
    assert_trig_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_opcode == OP_TRIG) |=> chirp_trigger && !status_req && $stable(cfg))
        else $error("trigger command misbehaved");

    // R8: status request copies the pre-edge registers
    assert_snap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_opcode == OP_STAT) |=> status_req && status_snapshot == $past(cfg))
        else $error("status snapshot mismatch");

    // R9: unlisted or unstrobed opcodes change nothing
    assert_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid || !op_known(cmd_opcode)) |=> $stable(cfg) && !chirp_trigger && !status_req)
        else $error("ignored command had an effect");

    // R11: snapshot only moves on a status request
    assert_snap_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_opcode == OP_STAT) |=> $stable(status_snapshot))
        else $error("snapshot moved without request");

endmodule

// File: tb/sim_host_cfg_decoder.sv
`timescale 1ns/1ps
module sim_host_cfg_decoder;

    localparam logic [15:0] D_THR = 16'd10000;
    localparam logic [1:0]  D_MODE = 2'd0;
    localparam logic [15:0] D_LC = 16'd3000;
    localparam logic [15:0] D_LL = 16'd13700;
    localparam logic [15:0] D_GD = 16'd17540;
    localparam logic [15:0] D_SC = 16'd50;
    localparam logic [15:0] D_SL = 16'd17450;
    localparam logic [5:0]  D_CPE = 6'd32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [7:0] cmd_opcode = 8'h00;
    logic [15:0] cmd_value = 16'h0000;
    logic [1:0] cfg_mode;
    logic [15:0] cfg_threshold, cfg_long_chirp, cfg_long_listen, cfg_guard;
    logic [15:0] cfg_short_chirp, cfg_short_listen;
    logic [2:0] cfg_streams;
    logic [5:0] cfg_chirps_per_elev;
    logic chirp_trigger, status_req;
    logic [106:0] status_snapshot;

    int n_chk = 0;
    int n_fail = 0;

    // bench model
    logic [15:0] m_thr = D_THR, m_lc = D_LC, m_ll = D_LL, m_gd = D_GD, m_sc = D_SC, m_sl = D_SL;
    logic [2:0]  m_str = 3'b111;
    logic [1:0]  m_mode = D_MODE;
    logic [5:0]  m_cpe = D_CPE;
    logic [106:0] m_snap;

    always #4 clk = ~clk;

    host_cfg_decoder #(
        .DEF_THRESHOLD(D_THR), .DEF_MODE(D_MODE), .DEF_LONG_CHIRP(D_LC),
        .DEF_LONG_LISTEN(D_LL), .DEF_GUARD(D_GD), .DEF_SHORT_CHIRP(D_SC),
        .DEF_SHORT_LISTEN(D_SL), .DEF_CPE(D_CPE)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode),
        .cmd_value(cmd_value), .cfg_mode(cfg_mode), .cfg_threshold(cfg_threshold),
        .cfg_streams(cfg_streams), .cfg_long_chirp(cfg_long_chirp),
        .cfg_long_listen(cfg_long_listen), .cfg_guard(cfg_guard),
        .cfg_short_chirp(cfg_short_chirp), .cfg_short_listen(cfg_short_listen),
        .cfg_chirps_per_elev(cfg_chirps_per_elev), .chirp_trigger(chirp_trigger),
        .status_req(status_req), .status_snapshot(status_snapshot)
    );

    function automatic logic [106:0] model_bundle();
        return {m_cpe, m_sl, m_sc, m_gd, m_ll, m_lc, m_mode, m_str, m_thr};
    endfunction

    function automatic logic [106:0] dut_bundle();
        return {cfg_chirps_per_elev, cfg_short_listen, cfg_short_chirp, cfg_guard,
                cfg_long_listen, cfg_long_chirp, cfg_mode, cfg_streams, cfg_threshold};
    endfunction

    function automatic string req_of(input logic [7:0] op);
        case (op)
            8'h01: return "R2";
            8'h02: return "R7";
            8'h03: return "R3";
            8'h04: return "R4";
            8'h10, 8'h11, 8'h12, 8'h13, 8'h14: return "R5";
            8'h15: return "R6";
            8'hFF: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_apply(input logic [7:0] op, input logic [15:0] v);
        case (op)
            8'h01: m_mode = v[1:0];
            8'h03: m_thr = v;
            8'h04: m_str = v[2:0];
            8'h10: m_lc = v;
            8'h11: m_ll = v;
            8'h12: m_gd = v;
            8'h13: m_sc = v;
            8'h14: m_sl = v;
            8'h15: m_cpe = v[5:0];
            8'hFF: m_snap = model_bundle();
            default: ;
        endcase
    endtask

    // one strobed command, then compare in the following cycle
    task automatic do_cmd(input logic [7:0] op, input logic [15:0] v);
        string r;
        r = req_of(op);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_opcode = op; cmd_value = v;
        @(negedge clk);
        cmd_valid = 1'b0;
        model_apply(op, v);
        chk(r, "registers", {21'd0, dut_bundle()}, {21'd0, model_bundle()});
        chk(r, "trigger", {127'd0, chirp_trigger}, {127'd0, (op == 8'h02)});
        chk(r, "status_req", {127'd0, status_req}, {127'd0, (op == 8'hFF)});
        chk(r, "snapshot", {21'd0, status_snapshot}, {21'd0, m_snap});
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        m_snap = model_bundle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "reset registers", {21'd0, dut_bundle()}, {21'd0, model_bundle()});
        chk("R1", "reset streams", {125'd0, cfg_streams}, {125'd0, 3'b111});
        chk("R1", "reset pulses", {126'd0, chirp_trigger, status_req}, 128'd0);
        chk("R1", "reset snapshot", {21'd0, status_snapshot}, {21'd0, m_snap});

        // full opcode sweep (R2..R9)
        for (int op = 0; op < 256; op++) begin
            logic [7:0] o;
            o = op[7:0];
            do_cmd(o, {o ^ 8'hA5, ~o});
        end

        // R4: every stream-enable pattern
        for (int s = 0; s < 8; s++) begin
            do_cmd(8'h04, 16'hFFF8 | 16'(s));
            chk("R4", "range bit0", {127'd0, cfg_streams[0]}, {127'd0, s[0]});
            chk("R4", "doppler bit1", {127'd0, cfg_streams[1]}, {127'd0, s[1]});
            chk("R4", "detect bit2", {127'd0, cfg_streams[2]}, {127'd0, s[2]});
        end
        // R2: every mode with upper bits set
        for (int md = 0; md < 4; md++) begin
            do_cmd(8'h01, 16'hFFFC | 16'(md));
            chk("R2", "mode", {126'd0, cfg_mode}, {126'd0, md[1:0]});
        end
        // R6: upper bits dropped
        do_cmd(8'h15, 16'hFFC5);
        chk("R6", "cpe", {122'd0, cfg_chirps_per_elev}, {122'd0, 6'h05});
        // R5: boundary values on each count
        for (int k = 0; k < 5; k++) begin
            do_cmd(8'h10 + 8'(k), 16'hFFFF);
            do_cmd(8'h10 + 8'(k), 16'h0001);
        end

        // R9: opcode present without strobe
        @(negedge clk);
        cmd_opcode = 8'h03; cmd_value = 16'h1234;
        @(negedge clk);
        chk("R9", "no strobe threshold", {112'd0, cfg_threshold}, {112'd0, m_thr});
        cmd_opcode = 8'h02;
        @(negedge clk);
        chk("R9", "no strobe trigger", {127'd0, chirp_trigger}, 128'd0);

        // R10: trigger, status, trigger back to back
        cmd_valid = 1'b1; cmd_opcode = 8'h02; cmd_value = 16'h0;
        @(negedge clk);
        chk("R10", "b2b t1 trig", {126'd0, chirp_trigger, status_req}, {126'd0, 2'b10});
        cmd_opcode = 8'hFF;
        @(negedge clk);
        model_apply(8'hFF, 16'h0);
        chk("R10", "b2b stat", {126'd0, chirp_trigger, status_req}, {126'd0, 2'b01});
        cmd_opcode = 8'h02;
        @(negedge clk);
        chk("R10", "b2b t2 trig", {126'd0, chirp_trigger, status_req}, {126'd0, 2'b10});
        cmd_opcode = 8'h02;
        @(negedge clk);
        chk("R10", "b2b t3 trig held", {126'd0, chirp_trigger, status_req}, {126'd0, 2'b10});
        cmd_valid = 1'b0;
        @(negedge clk);
        chk("R10", "pulse ends", {126'd0, chirp_trigger, status_req}, 128'd0);

        // R8: write then status on the next cycle captures the new value
        cmd_valid = 1'b1; cmd_opcode = 8'h03; cmd_value = 16'hBEEF;
        @(negedge clk);
        model_apply(8'h03, 16'hBEEF);
        cmd_opcode = 8'hFF;
        @(negedge clk);
        model_apply(8'hFF, 16'h0);
        chk("R8", "snapshot after write", {21'd0, status_snapshot}, {21'd0, m_snap});
        // R11: later write leaves the snapshot unchanged
        cmd_opcode = 8'h03; cmd_value = 16'h0F0F;
        @(negedge clk);
        model_apply(8'h03, 16'h0F0F);
        cmd_valid = 1'b0;
        chk("R11", "snapshot held", {21'd0, status_snapshot}, {21'd0, m_snap});
        chk("R11", "threshold moved", {112'd0, cfg_threshold}, {112'd0, 16'h0F0F});

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule